// File: doc/BRIEF.md
# Peak-Tracking Dynamic Range Gain Stage

This block applies dynamic range control to a stream of signed audio samples. It follows the peak level of the signal in decibels. The level rises toward louder samples at one programmable rate and falls back at a second, slower one. The block then feeds that level through a five-segment static gain curve and scales each sample by the resulting linear gain. The result appears one clock after the sample was offered.

The curve is built in the log domain, from the loudest segment to the quietest. A hard or soft limiter sits above the first knee. Two compression segments lie between the knees below it. The next segment is unity. An expander and a noise gate make up the two quietest segments. Each knee is set by a small code in 1 dB steps, and each segment has its own slope code. If three adjacent knees are given the same dB value, the curve collapses to a two-knee shape. When the enable input is low, every sample passes through unchanged. Even then, the level tracker keeps following the input.

Top module: `drc_gain_computer`

## Requirements
- R1: After reset, the output sample is 0 and the output strobe is low. The tracked level starts at the -96 dB floor.
- R2: A sample offered with the input strobe high appears on the output exactly one clock later, and the output strobe is high for that one clock. When no sample is offered, the output sample holds its value and the output strobe is low.
- R3: While the enable input is low, each output sample equals the input sample bit for bit.
- R4: The level of a sample is found from its magnitude. Saturate the magnitude so that the most negative code counts as full scale. Let z be the number of leading zeros of that magnitude over the 15 magnitude bits. The level is -6·z dB, and a zero sample reads -96 dB.
- R5: The tracked level is held with 16 fractional bits. On each sample whose level is at or above the tracked level (attack), the tracked level moves by the difference arithmetically shifted right by the attack code. Codes above 8 act as 8, and code 0 jumps straight to the new level.
- R6: On a sample whose level is below the tracked level (release), the shift is 6 plus the release code. The tracked level therefore falls gradually and never drops below the sample's level.
- R7: The curve reads e = floor of the tracked level after it has been updated with the current sample. Limiter knee K1 = -(code) dB. For a segment depth d ≥ 0 and a 3-bit slope code c, the gain term is -d for c=0, 0 for c=7, and floor(d/2^c) - d otherwise. The limiter depth is max(e-K1, 0).
- R8: K2 = -(6-bit code) dB and K3 = -18-(5-bit code) dB. The upper compression segment depth is e-K2 clipped to [0, K1-K2]. The lower compression segment depth is e-K3 clipped to [0, K2-K3]. A negative width counts as 0, so equal knees remove a segment.
- R9: K4 = -36-(code) dB and K5 = -54-(code) dB. The expander depth is K4-e clipped to [0, K4-K5], and the gate depth is max(K5-e, 0). Each of these segments has a 2-bit code c and adds -depth·(2^c - 1) dB.
- R10: The summed gain G is floored at -120 dB. With a = -G, the linear gain is L = T[a mod 6] >> (a div 6), where T = {32768, 29205, 26029, 23198, 20675, 18427} and 32768 stands for 1.0. The output is floor(x·L / 32768).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Gain processing enable; low passes samples through |
| smp_vld_i | input | 1 | Input sample strobe |
| smp_i | input | 16 | Signed input sample |
| att_code_i | input | 4 | Attack shift code |
| rel_code_i | input | 4 | Release shift code |
| knee1_code_i | input | 5 | Limiter knee code |
| knee2_code_i | input | 6 | Upper compression knee code |
| knee3_code_i | input | 5 | Lower compression knee code |
| knee4_code_i | input | 5 | Expander knee code |
| knee5_code_i | input | 5 | Gate knee code |
| lmt_slope_i | input | 3 | Limiter slope code |
| cmp1_slope_i | input | 3 | Upper compression slope code |
| cmp2_slope_i | input | 3 | Lower compression slope code |
| exp_slope_i | input | 2 | Expander ratio code |
| gate_slope_i | input | 2 | Gate ratio code |
| smp_o | output | 16 | Gain-adjusted sample |
| smp_vld_o | output | 1 | Output sample strobe |

## Verification
The bench places the tracked level exactly on a knee. A design with an off-by-one clip would reduce gain there instead of leaving the sample alone. It gives equal values to three knees and confirms that the curve becomes two segments, which a design without zero-width clipping would bend wrongly. It starts slow and fast attacks from the reset floor and runs a release after a loud sample. A tracker that starts at the wrong level or swaps the two shift codes would produce very different outputs on those samples. Two further cases check saturation and the gain floor. Full-scale positive and negative inputs must measure the same level. A very deep gate must reduce the output to zero rather than wrap.

// File: rtl/drc_pkg.sv
package drc_pkg;
  localparam int unsigned LIN_FRAC = 15;

  typedef struct packed {
    logic [4:0] k1;
    logic [5:0] k2;
    logic [4:0] k3;
    logic [4:0] k4;
    logic [4:0] k5;
    logic [2:0] s_lmt;
    logic [2:0] s_c1;
    logic [2:0] s_c2;
    logic [1:0] s_exp;
    logic [1:0] s_ng;
  } curve_cfg_t;

  // 10^(-r/20) in Q1.15 for the sub-6 dB remainder
  function automatic logic [15:0] frac_db_lin(input logic [2:0] r);
    case (r)
      3'd0:    frac_db_lin = 16'd32768;
      3'd1:    frac_db_lin = 16'd29205;
      3'd2:    frac_db_lin = 16'd26029;
      3'd3:    frac_db_lin = 16'd23198;
      3'd4:    frac_db_lin = 16'd20675;
      default: frac_db_lin = 16'd18427;
    endcase
  endfunction
endpackage

// File: rtl/drc_level_est.sv
module drc_level_est #(
  parameter int DW       = 16,
  parameter int LW       = 8,
  parameter int FR       = 16,
  parameter int FLOOR_DB = 96,
  parameter int ATT_MAX  = 8,
  parameter int REL_BASE = 6,
  localparam int EW      = LW + FR
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic [DW-1:0]        smp_i,
  input  logic [3:0]           att_i,
  input  logic [3:0]           rel_i,
  output logic signed [EW-1:0] env_nxt_o
);
  localparam int MW = DW - 1;

  logic [MW-1:0]        mag;
  int                   lz;
  int                   lvl_db;
  int                   delta;
  int                   sh;
  logic                 up;
  logic signed [EW-1:0] lvl_fx;
  logic signed [EW-1:0] env_q;
  logic signed [EW-1:0] env_nxt;

  always_comb begin
    if (!smp_i[DW-1])                            mag = smp_i[MW-1:0];
    else if (smp_i == {1'b1, {MW{1'b0}}})        mag = '1;
    else                                         mag = MW'(-smp_i);
  end

  always_comb begin
    lz = MW;
    for (int i = 0; i < MW; i++) if (mag[i]) lz = MW - 1 - i;
  end

  assign lvl_db = (mag == '0) ? -FLOOR_DB : -6 * lz;
  assign lvl_fx = EW'(lvl_db * (2 ** FR));

  always_comb begin
    delta = int'(lvl_fx) - int'(env_q);
    up    = (delta >= 0);
    if (up) sh = (int'(att_i) > ATT_MAX) ? ATT_MAX : int'(att_i);
    else    sh = REL_BASE + int'(rel_i);
    env_nxt = vld_i ? EW'(int'(env_q) + (delta >>> sh)) : env_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) env_q <= EW'(-FLOOR_DB * (2 ** FR));
    else         env_q <= env_nxt;
  end

  assign env_nxt_o = env_nxt;

  AST_ENV_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(env_q) >= -FLOOR_DB * (2 ** FR) && int'(env_q) <= 0); // R1
  AST_ATTACK_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && up && att_i == 4'd0) |=> env_q == $past(lvl_fx)); // R5
  AST_RELEASE_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !up) |=> (env_q < $past(env_q)) && (env_q >= $past(lvl_fx))); // R6
endmodule

// File: rtl/drc_gain_curve.sv
module drc_gain_curve
  import drc_pkg::*;
#(
  parameter int LW         = 8,
  parameter int FR         = 16,
  parameter int GW         = 12,
  parameter int GAIN_FLOOR = 120,
  parameter int K3_BASE    = 18,
  parameter int K4_BASE    = 36,
  parameter int K5_BASE    = 54,
  localparam int EW        = LW + FR
) (
  input  logic signed [EW-1:0] env_i,
  input  curve_cfg_t           cfg_i,
  output logic signed [GW-1:0] gain_o
);
  function automatic int clip(input int v, input int w);
    if (w <= 0 || v <= 0) return 0;
    return (v > w) ? w : v;
  endfunction

  function automatic int seg(input int d, input logic [2:0] c);
    if (c == 3'd0) return -d;
    if (c == 3'd7) return 0;
    return (d >>> int'(c)) - d;
  endfunction

  int e, k1, k2, k3, k4, k5, g;

  always_comb begin
    e  = int'(env_i) >>> FR;
    k1 = -int'(cfg_i.k1);
    k2 = -int'(cfg_i.k2);
    k3 = -K3_BASE - int'(cfg_i.k3);
    k4 = -K4_BASE - int'(cfg_i.k4);
    k5 = -K5_BASE - int'(cfg_i.k5);
    g  = seg((e > k1) ? e - k1 : 0, cfg_i.s_lmt);
    g += seg(clip(e - k2, k1 - k2), cfg_i.s_c1);
    g += seg(clip(e - k3, k2 - k3), cfg_i.s_c2);
    g -= clip(k4 - e, k4 - k5) * ((1 << int'(cfg_i.s_exp)) - 1);
    g -= ((k5 > e) ? k5 - e : 0) * ((1 << int'(cfg_i.s_ng)) - 1);
    if (g < -GAIN_FLOOR) g = -GAIN_FLOOR;
    gain_o = GW'(g);
  end
endmodule

// File: rtl/drc_gain_apply.sv
module drc_gain_apply
  import drc_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 en_i,
  input  logic [DW-1:0]        smp_i,
  input  logic signed [GW-1:0] gain_i,
  output logic [DW-1:0]        smp_o,
  output logic                 vld_o
);
  int          att_db, q, r;
  logic [15:0] lin;
  longint      prod;
  logic [DW-1:0] smp_d;

  always_comb begin
    att_db = -int'(gain_i);
    q      = att_db / 6;
    r      = att_db % 6;
    lin    = (q > 15) ? 16'd0 : (frac_db_lin(3'(r)) >> q);
    prod   = longint'($signed(smp_i)) * longint'({1'b0, lin});
    smp_d  = en_i ? DW'(prod >>> LIN_FRAC) : smp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) smp_o <= smp_d;
    end
  end

  function automatic logic [DW:0] mag_of(input logic [DW-1:0] v);
    return v[DW-1] ? (DW+1)'(-{1'b1, v}) : {1'b0, v};
  endfunction

  AST_STROBE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o); // R2
  AST_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o && $stable(smp_o)); // R2
  AST_BYPASS_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !en_i) |=> smp_o == $past(smp_i)); // R3
  AST_NO_BOOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && en_i) |=> mag_of(smp_o) <= mag_of($past(smp_i))); // R10
endmodule

// File: rtl/drc_gain_computer.sv
module drc_gain_computer
  import drc_pkg::*;
#(
  parameter int DW         = 16,
  parameter int LW         = 8,
  parameter int FR         = 16,
  parameter int FLOOR_DB   = 96,
  parameter int GAIN_FLOOR = 120,
  localparam int EW        = LW + FR,
  localparam int GW        = $clog2(GAIN_FLOOR * 16) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          smp_vld_i,
  input  logic [DW-1:0] smp_i,
  input  logic [3:0]    att_code_i,
  input  logic [3:0]    rel_code_i,
  input  logic [4:0]    knee1_code_i,
  input  logic [5:0]    knee2_code_i,
  input  logic [4:0]    knee3_code_i,
  input  logic [4:0]    knee4_code_i,
  input  logic [4:0]    knee5_code_i,
  input  logic [2:0]    lmt_slope_i,
  input  logic [2:0]    cmp1_slope_i,
  input  logic [2:0]    cmp2_slope_i,
  input  logic [1:0]    exp_slope_i,
  input  logic [1:0]    gate_slope_i,
  output logic [DW-1:0] smp_o,
  output logic          smp_vld_o
);
  curve_cfg_t           cfg;
  logic signed [EW-1:0] env_nxt;
  logic signed [GW-1:0] gain_db;

  assign cfg = '{k1: knee1_code_i, k2: knee2_code_i, k3: knee3_code_i,
                 k4: knee4_code_i, k5: knee5_code_i, s_lmt: lmt_slope_i,
                 s_c1: cmp1_slope_i, s_c2: cmp2_slope_i,
                 s_exp: exp_slope_i, s_ng: gate_slope_i};

  drc_level_est #(.DW(DW), .LW(LW), .FR(FR), .FLOOR_DB(FLOOR_DB)) u_level (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (smp_vld_i),
    .smp_i    (smp_i),
    .att_i    (att_code_i),
    .rel_i    (rel_code_i),
    .env_nxt_o(env_nxt)
  );

  drc_gain_curve #(.LW(LW), .FR(FR), .GW(GW), .GAIN_FLOOR(GAIN_FLOOR)) u_curve (
    .env_i (env_nxt),
    .cfg_i (cfg),
    .gain_o(gain_db)
  );

  drc_gain_apply #(.DW(DW), .GW(GW)) u_apply (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (smp_vld_i),
    .en_i  (en_i),
    .smp_i (smp_i),
    .gain_i(gain_db),
    .smp_o (smp_o),
    .vld_o (smp_vld_o)
  );

  AST_GAIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i |-> (int'(gain_db) <= 0 && int'(gain_db) >= -GAIN_FLOOR)); // R10
endmodule

// File: tb/drc_gain_computer_bench.sv
module drc_gain_computer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        vld = 1'b0;
  logic [15:0] smp = '0;
  logic [3:0]  att = '0, rel = '0;
  logic [4:0]  k1 = '0, k3 = '0, k4 = '0, k5 = '0;
  logic [5:0]  k2 = '0;
  logic [2:0]  s_lmt = 3'd7, s_c1 = 3'd7, s_c2 = 3'd7;
  logic [1:0]  s_exp = '0, s_ng = '0;
  logic [15:0] out;
  logic        out_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  drc_gain_computer u_drc_gain_computer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .smp_vld_i(vld), .smp_i(smp),
    .att_code_i(att), .rel_code_i(rel),
    .knee1_code_i(k1), .knee2_code_i(k2), .knee3_code_i(k3),
    .knee4_code_i(k4), .knee5_code_i(k5),
    .lmt_slope_i(s_lmt), .cmp1_slope_i(s_c1), .cmp2_slope_i(s_c2),
    .exp_slope_i(s_exp), .gate_slope_i(s_ng),
    .smp_o(out), .smp_vld_o(out_vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic neutral();
    en = 1'b1; att = '0; rel = '0;
    k1 = '0; k2 = '0; k3 = '0; k4 = '0; k5 = '0;
    s_lmt = 3'd7; s_c1 = 3'd7; s_c2 = 3'd7; s_exp = '0; s_ng = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic send(input int x, output int y);
    @(negedge clk); smp = 16'(x); vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    y = int'($signed(out));
  endtask

  task automatic t_reset();
    chk("R1 out after reset", int'(out), 0);
    chk("R1 strobe after reset", int'(out_vld), 0);
  endtask

  task automatic t_strobe();
    int y;
    neutral(); en = 1'b0;
    @(negedge clk); smp = 16'd1234; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    chk("R2 strobe one clock later", int'(out_vld), 1);
    chk("R2 sample one clock later", int'($signed(out)), 1234);
    smp = 16'd999;
    @(negedge clk);
    chk("R2 strobe drops", int'(out_vld), 0);
    @(negedge clk);
    chk("R2 output held while idle", int'($signed(out)), 1234);
    send(-77, y);
    chk("R2 next sample", y, -77);
  endtask

  task automatic t_bypass();
    int y;
    neutral(); en = 1'b0; s_lmt = 3'd0; k1 = 5'd31; s_ng = 2'd3;
    send(32767, y);  chk("R3 bypass full scale", y, 32767);
    send(-32768, y); chk("R3 bypass most negative", y, -32768);
    send(5, y);      chk("R3 bypass small", y, 5);
  endtask

  task automatic t_attack_slow();
    int y;
    do_reset(); neutral(); att = 4'd3; k1 = 5'd31; s_lmt = 3'd0;
    // floor -96 plus 1/8 of 96 dB -> -84 dB, below the -31 dB knee
    send(32767, y); chk("R5 R1 slow attack from floor", y, 32767);
  endtask

  task automatic t_level_and_release();
    int y;
    do_reset(); neutral(); k1 = 5'd31; s_lmt = 3'd0;
    // 0 dB, gain -31 -> 29205>>5 = 912
    send(-32768, y); chk("R4 saturated negative level", y, -912);
    send(32767, y);  chk("R4 positive full scale level", y, 911);
    // 1024 is -24 dB; release shift 6 leaves e=-1, gain -30 -> 1024
    send(1024, y);   chk("R6 slow release", y, 32);
  endtask

  task automatic t_limiter();
    int y;
    do_reset(); neutral(); k1 = 5'd12; k2 = 6'd20; s_lmt = 3'd0;
    send(32767, y); chk("R7 hard limit slope 0", y, 8191);
    s_lmt = 3'd2;
    send(32767, y); chk("R7 slope 1/4 above knee", y, 11598);
    s_lmt = 3'd7;
    send(32767, y); chk("R7 slope code 7 unity", y, 32767);
  endtask

  task automatic t_expander_gate();
    int y;
    do_reset(); neutral(); s_exp = 2'd1; s_ng = 2'd2;
    send(8, y);   chk("R9 gate and expander combined", y, 0);
    send(128, y); chk("R9 expander 2:1 six dB under knee", y, 64);
    send(256, y); chk("R9 exactly on expander knee", y, 256);
  endtask

  task automatic t_compressor();
    int y;
    do_reset(); neutral(); k1 = 5'd0; k2 = 6'd6; k3 = 5'd0;
    s_lmt = 3'd0; s_c1 = 3'd2; s_c2 = 3'd1;
    send(2048, y);  chk("R8 exactly on lower knee", y, 2048);
    send(8192, y);  chk("R8 lower segment 1/2", y, 4096);
    send(32767, y); chk("R8 R10 both segments remainder 5", y, 9212);
  endtask

  task automatic t_two_knee();
    int y;
    do_reset(); neutral(); k1 = 5'd12; k2 = 6'd36; k3 = 5'd18; k4 = 5'd0;
    k5 = 5'd31; s_c1 = 3'd1; s_c2 = 3'd0; s_exp = 2'd1;
    send(256, y);  chk("R8 shared knee unity", y, 256);
    send(2048, y); chk("R8 two-knee shape", y, 724);
  endtask

  task automatic t_floor();
    int y;
    do_reset(); neutral(); s_ng = 2'd3;
    send(1, y);  chk("R10 gain floor positive", y, 0);
    send(-1, y); chk("R10 gain floor negative", y, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_strobe();
    t_bypass();
    t_attack_slow();
    t_level_and_release();
    t_limiter();
    t_expander_gate();
    t_compressor();
    t_two_knee();
    t_floor();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: done %0d expected 1", done);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule